// File: doc/BRIEF.md
# Sequential Read Power Gating for a Four-Way Cache

This block sits in front of the tag and data RAMs of a four-way set-associative cache read port. It decides, for every read request, which RAMs actually need to be powered for that cycle. Each line holds eight 32-bit words. Every way's data store is split into two 32-bit RAMs: one holds the even-numbered words of each line and the other holds the odd-numbered words. The read path is 64 bits wide.

The controller remembers three things: the word address and width of the last read, and the way that read hit in. A read may continue directly from the previous one (its address is the previous address plus one word for a narrow read, or plus two words for a wide read) and stay inside the same line. Such a read leaves the tag RAM off and enables only the data RAM halves of the remembered way. Every other read performs a full lookup: the tag RAM is enabled, and the needed halves in all ways are enabled.

Whether a read is full or reused, only the halves that hold the requested words are switched on. A 32-bit read therefore wakes a single RAM per enabled way. The hit result of a full lookup comes back from the tag compare logic in the following cycle, and the controller captures it there. Writes and maintenance operations discard what the controller remembers.

Top module: `seqrd_gate`

## Requirements
- R1: After reset nothing is tracked, so the first read performs a full lookup.
- R2: A full lookup drives tag_en high and enables each needed RAM half in every way (even_en and odd_en are each all-ones or all-zeros).
- R3: A read reuses the tracked way when all of the following hold. Its word address equals the previous read's address plus 1 (narrow) or plus 2 (wide), modulo the address space. Its bits above the low three equal those of the previous read. The previous read's way is known to have hit. On reuse, tag_en is low and only that way's needed halves are enabled. Idle cycles between the two reads do not break the tracking.
- R4: A narrow read (rd_wide=0) enables only the even RAM when address bit 0 is 0, and only the odd RAM when it is 1. The index is the address shifted right by one.
- R5: A wide read starting on an even word enables both halves, both at index rd_addr>>1.
- R6: A wide read starting on an odd word uses two indices. The odd RAM is read at rd_addr>>1. The even RAM is read at the next word pair of the same line, so a read starting at word 7 wraps to the line's first pair (index = line number × 4).
- R7: A read whose address does not continue from the previous read performs a full lookup.
- R8: A read that continues from the previous read but lies in a different line performs a full lookup.
- R9: A write or maintenance cycle forces the next read to perform a full lookup. A read presented in that same cycle still uses the tracking from before.
- R10: If hit_valid is low in the cycle after a full lookup (a miss), the next read performs a full lookup.
- R11: hit_valid and hit_way are taken in the cycle after a full lookup. A read in that same cycle may reuse the way given by hit_way directly.
- R12: In a cycle with no read, tag_en, even_en and odd_en are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_valid | input | 1 | Read request this cycle |
| rd_addr | input | ADDR_W | Word address of the read |
| rd_wide | input | 1 | 1 = 64-bit read (two words), 0 = 32-bit read |
| wr_valid | input | 1 | Write to the cache this cycle |
| maint_valid | input | 1 | Maintenance operation this cycle |
| hit_valid | input | 1 | Tag compare reported a hit (cycle after a lookup) |
| hit_way | input | $clog2(WAYS) | Way that hit (cycle after a lookup) |
| tag_en | output | 1 | Tag RAM enable |
| even_en | output | WAYS | Per-way enable of the even-word data RAM |
| odd_en | output | WAYS | Per-way enable of the odd-word data RAM |
| even_idx | output | ADDR_W-1 | Even-word RAM index |
| odd_idx | output | ADDR_W-1 | Odd-word RAM index |

## Verification
The bench tries several kinds of read sequence:
- Runs of narrow and wide reads that continue from one another. These separate reuse from lookup and exercise the odd/even half selection.
- Reads that skip a word or step into the next line. These show that a gap or a line boundary forces a full lookup.
- Wide reads starting on odd words, including the last word of a line. These expose the split index and the wrap back to the start of the line.
- Writes, maintenance cycles and a missed lookup placed between reads, plus a read issued in the same cycle as the hit response. These show which events discard the tracked way and when the newly reported way can be used.

// File: rtl/seqrd_pkg.sv
package seqrd_pkg;
   typedef enum logic [1:0] {
      ACC_NONE   = 2'd0,
      ACC_LOOKUP = 2'd1,
      ACC_REUSE  = 2'd2
   } acc_kind_e;
endpackage

// File: rtl/seqrd_track.sv
module seqrd_track
   import seqrd_pkg::*;
#(
   parameter int WAYS       = 4,
   parameter int ADDR_W     = 10,
   parameter int LINE_WORDS = 8,
   localparam int OFF_W     = $clog2(LINE_WORDS),
   localparam int WAY_W     = $clog2(WAYS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_wide,
   input  logic              wr_valid,
   input  logic              maint_valid,
   input  logic              hit_valid,
   input  logic [WAY_W-1:0]  hit_way,
   output acc_kind_e         kind,
   output logic [WAY_W-1:0]  cur_way
);
   logic              trk_vld_q;
   logic              pend_q;
   logic              prev_wide_q;
   logic [WAY_W-1:0]  way_q;
   logic [ADDR_W-1:0] prev_addr_q;

   logic              way_known;
   logic [ADDR_W-1:0] next_addr;
   logic              is_seq;
   logic              in_line;

   // The hit result of a lookup is only on the pins one cycle later.
   assign way_known = pend_q ? hit_valid : trk_vld_q;
   assign cur_way   = pend_q ? hit_way   : way_q;

   assign next_addr = prev_addr_q + (prev_wide_q ? ADDR_W'(2) : ADDR_W'(1));
   assign is_seq    = (rd_addr == next_addr);
   assign in_line   = (rd_addr[ADDR_W-1:OFF_W] == prev_addr_q[ADDR_W-1:OFF_W]);

   always_comb begin
      if (!rd_valid)
         kind = ACC_NONE;
      else if (way_known && is_seq && in_line)
         kind = ACC_REUSE;
      else
         kind = ACC_LOOKUP;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         trk_vld_q   <= 1'b0;
         pend_q      <= 1'b0;
         prev_wide_q <= 1'b0;
         way_q       <= '0;
         prev_addr_q <= '0;
      end else if (wr_valid || maint_valid) begin
         trk_vld_q <= 1'b0;
         pend_q    <= 1'b0;
      end else if (rd_valid) begin
         prev_addr_q <= rd_addr;
         prev_wide_q <= rd_wide;
         if (kind == ACC_REUSE) begin
            trk_vld_q <= 1'b1;
            way_q     <= cur_way;
            pend_q    <= 1'b0;
         end else begin
            trk_vld_q <= 1'b0;
            pend_q    <= 1'b1;
         end
      end else if (pend_q) begin
         trk_vld_q <= hit_valid;
         way_q     <= hit_way;
         pend_q    <= 1'b0;
      end
   end
endmodule

// File: rtl/seqrd_halfsel.sv
module seqrd_halfsel #(
   parameter int ADDR_W     = 10,
   parameter int LINE_WORDS = 8,
   localparam int OFF_W     = $clog2(LINE_WORDS),
   localparam int IDX_W     = ADDR_W - 1
) (
   input  logic              rd_wide,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              need_even,
   output logic              need_odd,
   output logic [IDX_W-1:0]  even_idx,
   output logic [IDX_W-1:0]  odd_idx
);
   logic             odd_start;
   logic [IDX_W-1:0] pair_idx;
   logic [IDX_W-1:0] wrap_idx;

   assign odd_start = rd_addr[0];
   assign pair_idx  = rd_addr[ADDR_W-1:1];

   generate
      if (OFF_W == 1) begin : g_two_word_line
         // Next pair of a two-word line is the line itself.
         assign wrap_idx = pair_idx;
      end else begin : g_multi_pair_line
         logic [OFF_W-2:0] nxt_pair;
         assign nxt_pair = rd_addr[OFF_W-1:1] + 1'b1;
         assign wrap_idx = {rd_addr[ADDR_W-1:OFF_W], nxt_pair};
      end
   endgenerate

   assign need_even = rd_wide || !odd_start;
   assign need_odd  = rd_wide ||  odd_start;
   assign odd_idx   = pair_idx;
   assign even_idx  = (rd_wide && odd_start) ? wrap_idx : pair_idx;
endmodule

// File: rtl/seqrd_wayen.sv
module seqrd_wayen
   import seqrd_pkg::*;
#(
   parameter int WAYS   = 4,
   localparam int WAY_W = $clog2(WAYS)
) (
   input  acc_kind_e        kind,
   input  logic [WAY_W-1:0] cur_way,
   input  logic             need_even,
   input  logic             need_odd,
   output logic             tag_en,
   output logic [WAYS-1:0]  even_en,
   output logic [WAYS-1:0]  odd_en
);
   assign tag_en = (kind == ACC_LOOKUP);

   generate
      for (genvar w = 0; w < WAYS; w++) begin : g_way
         logic way_on;
         assign way_on = (kind == ACC_LOOKUP) ||
                         ((kind == ACC_REUSE) && (cur_way == WAY_W'(w)));
         assign even_en[w] = way_on && need_even;
         assign odd_en[w]  = way_on && need_odd;
      end
   endgenerate
endmodule

// File: rtl/seqrd_gate.sv
module seqrd_gate
   import seqrd_pkg::*;
#(
   parameter int WAYS       = 4,
   parameter int ADDR_W     = 10,
   parameter int LINE_WORDS = 8,
   localparam int WAY_W     = $clog2(WAYS),
   localparam int OFF_W     = $clog2(LINE_WORDS),
   localparam int IDX_W     = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic              rd_wide,
   input  logic              wr_valid,
   input  logic              maint_valid,
   input  logic              hit_valid,
   input  logic [WAY_W-1:0]  hit_way,
   output logic              tag_en,
   output logic [WAYS-1:0]   even_en,
   output logic [WAYS-1:0]   odd_en,
   output logic [IDX_W-1:0]  even_idx,
   output logic [IDX_W-1:0]  odd_idx
);
   generate
      if (WAYS < 2 || (1 << WAY_W) != WAYS) begin : g_bad_ways
         $error("seqrd_gate: WAYS must be a power of two of at least 2");
      end
      if (LINE_WORDS < 2 || (1 << OFF_W) != LINE_WORDS) begin : g_bad_line
         $error("seqrd_gate: LINE_WORDS must be a power of two of at least 2");
      end
      if (ADDR_W <= OFF_W) begin : g_bad_addr
         $error("seqrd_gate: ADDR_W must exceed the line offset width");
      end
   endgenerate

   acc_kind_e        kind;
   logic [WAY_W-1:0] cur_way;
   logic             need_even;
   logic             need_odd;

   seqrd_track #(
      .WAYS(WAYS), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)
   ) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .rd_valid   (rd_valid),
      .rd_addr    (rd_addr),
      .rd_wide    (rd_wide),
      .wr_valid   (wr_valid),
      .maint_valid(maint_valid),
      .hit_valid  (hit_valid),
      .hit_way    (hit_way),
      .kind       (kind),
      .cur_way    (cur_way)
   );

   seqrd_halfsel #(
      .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)
   ) u_halfsel (
      .rd_wide  (rd_wide),
      .rd_addr  (rd_addr),
      .need_even(need_even),
      .need_odd (need_odd),
      .even_idx (even_idx),
      .odd_idx  (odd_idx)
   );

   seqrd_wayen #(
      .WAYS(WAYS)
   ) u_wayen (
      .kind     (kind),
      .cur_way  (cur_way),
      .need_even(need_even),
      .need_odd (need_odd),
      .tag_en   (tag_en),
      .even_en  (even_en),
      .odd_en   (odd_en)
   );
endmodule

// File: rtl/seqrd_gate_chk.sv
module seqrd_gate_chk #(
   parameter int WAYS       = 4,
   parameter int ADDR_W     = 10,
   parameter int LINE_WORDS = 8,
   localparam int WAY_W     = $clog2(WAYS),
   localparam int IDX_W     = ADDR_W - 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_valid,
   input logic [ADDR_W-1:0] rd_addr,
   input logic              rd_wide,
   input logic              wr_valid,
   input logic              maint_valid,
   input logic              hit_valid,
   input logic [WAY_W-1:0]  hit_way,
   input logic              tag_en,
   input logic [WAYS-1:0]   even_en,
   input logic [WAYS-1:0]   odd_en,
   input logic [IDX_W-1:0]  even_idx,
   input logic [IDX_W-1:0]  odd_idx
);
   logic [WAYS-1:0] any_en;
   assign any_en = even_en | odd_en;

   a_r12_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_valid |-> (!tag_en && even_en == '0 && odd_en == '0));

   a_r2_lookup_all_ways: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && tag_en) |->
         ((even_en == '0 || &even_en) && (odd_en == '0 || &odd_en) && any_en != '0));

   a_r3_reuse_single_way: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !tag_en) |-> ($countones(any_en) == 1));

   a_r4_narrow_one_half: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_wide) |->
         ((|even_en) == !rd_addr[0] && (|odd_en) == rd_addr[0]));

   a_r4_narrow_index: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_wide) |-> (odd_idx == rd_addr[ADDR_W-1:1]));

   a_r5_wide_both_halves: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_wide) |-> ((even_en == odd_en) && (|even_en)));

   a_r5_wide_even_same_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && rd_wide && !rd_addr[0]) |-> (even_idx == odd_idx));

   a_r9_write_forces_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_valid || maint_valid) |=> (rd_valid |-> tag_en));

   a_r10_miss_forces_lookup: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && tag_en && !wr_valid && !maint_valid) |=>
         ((rd_valid && !hit_valid) |-> tag_en));

   a_r11_bypass_way: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && tag_en && !wr_valid && !maint_valid) |=>
         ((rd_valid && !tag_en) |-> (any_en == (WAYS'(1) << hit_way))));
endmodule

bind seqrd_gate seqrd_gate_chk #(
   .WAYS(WAYS), .ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)
) u_chk (.*);

// File: tb/tb_seqrd_gate.sv
module tb_seqrd_gate;
   localparam int WAYS   = 4;
   localparam int ADDR_W = 10;
   localparam int LINEW  = 8;
   localparam int ASPACE = 1 << ADDR_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              rd_valid = 1'b0;
   logic [ADDR_W-1:0] rd_addr = '0;
   logic              rd_wide = 1'b0;
   logic              wr_valid = 1'b0;
   logic              maint_valid = 1'b0;
   logic              hit_valid = 1'b0;
   logic [1:0]        hit_way = '0;
   logic              tag_en;
   logic [WAYS-1:0]   even_en;
   logic [WAYS-1:0]   odd_en;
   logic [ADDR_W-2:0] even_idx;
   logic [ADDR_W-2:0] odd_idx;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // Reference state: what a correct controller would remember.
   bit m_known = 0;
   bit m_wait  = 0;
   int m_way   = 0;
   int m_prev  = 0;
   bit m_pwide = 0;

   seqrd_gate #(.WAYS(WAYS), .ADDR_W(ADDR_W), .LINE_WORDS(LINEW)) dut (
      .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_addr(rd_addr),
      .rd_wide(rd_wide), .wr_valid(wr_valid), .maint_valid(maint_valid),
      .hit_valid(hit_valid), .hit_way(hit_way), .tag_en(tag_en),
      .even_en(even_en), .odd_en(odd_en), .even_idx(even_idx), .odd_idx(odd_idx)
   );

   always #10 clk = ~clk;

   always @(posedge clk) begin
      cycles++;
      if (cycles > 5000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input string req, input bit rd, input int addr, input bit wide,
                       input bit wr, input bit mt, input bit hv, input int hw);
      bit known_now, reuse, ne, no;
      int way_now, w, line, eidx, oidx, en_e, en_o;
      @(negedge clk);
      rd_valid = rd; rd_addr = addr[ADDR_W-1:0]; rd_wide = wide;
      wr_valid = wr; maint_valid = mt; hit_valid = hv; hit_way = hw[1:0];
      #5;
      known_now = m_wait ? hv : m_known;
      way_now   = m_wait ? hw : m_way;
      reuse = rd && known_now &&
              (((m_prev + (m_pwide ? 2 : 1)) % ASPACE) == addr) &&
              ((addr / LINEW) == (m_prev / LINEW));
      w = addr % LINEW; line = addr / LINEW;
      ne = wide || (w % 2 == 0);
      no = wide || (w % 2 == 1);
      oidx = addr / 2;
      eidx = (wide && (w % 2 == 1)) ? line * (LINEW / 2) + ((w + 1) % LINEW) / 2 : addr / 2;
      en_e = 0; en_o = 0;
      for (int k = 0; k < WAYS; k++) begin
         if (rd && (!reuse || k == way_now)) begin
            if (ne) en_e |= (1 << k);
            if (no) en_o |= (1 << k);
         end
      end
      chk(req, "tag_en", int'(tag_en), int'(rd && !reuse));
      chk(req, "even_en", int'(even_en), en_e);
      chk(req, "odd_en", int'(odd_en), en_o);
      if (rd && ne) chk(req, "even_idx", int'(even_idx), eidx);
      if (rd && no) chk(req, "odd_idx", int'(odd_idx), oidx);
      // advance the reference past the coming clock edge
      if (wr || mt) begin
         m_known = 0; m_wait = 0;
      end else if (rd) begin
         m_prev = addr; m_pwide = wide;
         if (reuse) begin m_known = 1; m_way = way_now; m_wait = 0; end
         else begin m_known = 0; m_wait = 1; end
      end else if (m_wait) begin
         m_known = hv; m_way = hw; m_wait = 0;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step("R12", 0, 0,     0, 0, 0, 0, 0);
      step("R1",  1, 'h10,  0, 0, 0, 0, 0);
      step("R12", 0, 0,     0, 0, 0, 1, 2);
      step("R3",  1, 'h11,  0, 0, 0, 0, 0);
      step("R5",  1, 'h12,  1, 0, 0, 0, 0);
      step("R5",  1, 'h14,  1, 0, 0, 0, 0);
      step("R5",  1, 'h16,  1, 0, 0, 0, 0);
      step("R8",  1, 'h18,  0, 0, 0, 0, 0);
      step("R11", 1, 'h19,  0, 0, 0, 1, 1);
      step("R7",  1, 'h1B,  1, 0, 0, 0, 0);
      step("R6",  1, 'h1D,  1, 0, 0, 1, 3);
      step("R6",  1, 'h1F,  1, 0, 0, 0, 0);
      step("R2",  1, 'h30,  0, 0, 0, 0, 0);
      step("R12", 0, 0,     0, 0, 0, 1, 0);
      step("R9",  0, 0,     0, 1, 0, 0, 0);
      step("R9",  1, 'h31,  0, 0, 0, 0, 0);
      step("R10", 0, 0,     0, 0, 0, 0, 1);
      step("R10", 1, 'h32,  0, 0, 0, 0, 0);
      step("R12", 0, 0,     0, 0, 0, 1, 2);
      step("R9",  0, 0,     0, 0, 1, 0, 0);
      step("R9",  1, 'h33,  0, 0, 0, 0, 0);
      step("R12", 0, 0,     0, 0, 0, 1, 2);
      step("R9",  1, 'h34,  0, 1, 0, 0, 0);
      step("R9",  1, 'h35,  0, 0, 0, 0, 0);
      step("R12", 0, 0,     0, 0, 0, 1, 1);
      step("R12", 0, 0,     0, 0, 0, 0, 3);
      step("R3",  1, 'h36,  0, 0, 0, 0, 0);
      step("R4",  1, 'h37,  0, 0, 0, 0, 0);
      step("R7",  1, 'h37,  0, 0, 0, 0, 0);
      step("R4",  1, 'h3A,  0, 0, 0, 0, 0);
      @(negedge clk);
      rd_valid = 1'b0;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule